// File: doc/BRIEF.md
# Multi-channel phase-offset PWM engine

This block drives a set of pulse-width outputs from one shared, free-running 12-bit time base. A prescaler divides the input clock, and each time it expires the shared counter steps forward by one count. The counter runs from 0 to 4095 and then wraps. Each channel places its pulse anywhere in that 4096-count period using two compare points: a rise count and a fall count. Because the rise count does not have to be zero, channels can be spread across the period so that they do not all switch at once. A window may also straddle the wrap, so that it starts near the end of one period and ends early in the next.

Every channel has two override flags. The force-low flag wins over everything else. The force-high flag holds the line high for the whole period. Rise and fall counts are double-buffered and are taken in only at the period boundary, so a period is never cut short. A global invert control flips every output. A sleep control freezes the time base and parks every output at its idle level. All settings arrive as parallel inputs from surrounding logic.

Top module: `pwm_phase_engine`

## Requirements
- R1: While rst_n is low, every output is 0. Reset clears the counter and the prescaler phase to 0 and clears the buffered rise and fall counts to 0.
- R2: While awake, the counter advances by one count once every E+1 clocks, where E = max(prescale, 3). Prescale values 0 to 2 therefore behave as 3. The counter wraps from 4095 to 0.
- R3: When neither flag is set, a channel's active level is 1 while (count − rise) mod 4096 < (fall − rise) mod 4096. If the fall count is below the rise count, the pulse wraps across the rollover. Each output is registered: it reflects the counter value, buffered counts and inputs present just before the clock edge.
- R4: When the buffered rise count equals the buffered fall count and neither flag is set, the active level stays 0 for the whole period.
- R5: A set forceOff bit makes that channel's active level 0, whatever its forceOn bit and compare counts are.
- R6: A set forceOn bit with forceOff clear makes that channel's active level 1 for the whole period.
- R7: When invert is 1, every output pin carries the inverse of its active level.
- R8: While sleep is 1, the counter and prescaler hold their values. Each output is driven to the value of invert, which is its idle level.
- R9: The riseCount and fallCount inputs are copied into the buffered counts on the clock edge where the counter steps from 4095 to 0, and on every edge while sleep is 1. The forceOn and forceOff bits act on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prescale | input | 8 | Clock divide setting. The counter steps every max(prescale,3)+1 clocks |
| sleep | input | 1 | Freezes the time base and parks the outputs at their idle level |
| invert | input | 1 | Global output polarity flip |
| riseCount | input | 16*12 | Rise compare for each channel. Channel c uses bits [12c+11:12c] |
| fallCount | input | 16*12 | Fall compare for each channel, packed the same way |
| forceOn | input | 16 | Bit c forces channel c high (lower priority) |
| forceOff | input | 16 | Bit c forces channel c low (highest priority) |
| pwmOut | output | 16 | Pulse outputs, registered |

## Verification
Every output bit is due one clock after the edge that consumed the counter value, the buffered counts and the control inputs it depends on. Counter steps and loads of the buffered counts happen on that same edge. The bench keeps its own model of the counter, the prescaler phase and the buffered counts. It drives all inputs at the falling edge. There it predicts the value each output takes at the next rising edge, and compares on the falling edge that follows. Each channel is checked on every clock, so both the timing of the prescaler and the moment when buffered counts are loaded at the wrap are checked to the exact cycle.

// File: rtl/pwm_phase_pkg.sv
package pwm_phase_pkg;
  // Strobes the time base hands to the channel datapath each cycle.
  typedef struct packed {
    logic hold;  // time base frozen (sleep)
    logic tick;  // counter steps on this edge
    logic load;  // copy compare inputs into the buffered counts on this edge
  } pwm_strobe_t;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_phase_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int PRE_W   = 8,
  parameter int PRE_MIN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] prescale,
  input  logic             sleep,
  output logic [CNT_W-1:0] cntVal,
  output pwm_strobe_t      strobe
);
  localparam logic [CNT_W-1:0] CNT_LAST  = '1;
  localparam logic [PRE_W-1:0] PRE_FLOOR = PRE_W'(PRE_MIN);

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] presEff;
  logic             tickNow;

  // Prescale values below the floor behave as the floor.
  always_comb presEff = (prescale < PRE_FLOOR) ? PRE_FLOOR : prescale;
  // ">=" keeps the divider from stalling when prescale is lowered mid-count.
  always_comb tickNow = !sleep && (preCnt >= presEff);

  always_comb begin
    strobe.hold = sleep;
    strobe.tick = tickNow;
    strobe.load = sleep || (tickNow && (cntVal == CNT_LAST));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      preCnt <= '0;
      cntVal <= '0;
    end else if (tickNow) begin
      preCnt <= '0;
      cntVal <= cntVal + CNT_W'(1);
    end else if (!sleep) begin
      preCnt <= preCnt + PRE_W'(1);
    end
  end
endmodule

// File: rtl/pwm_channel_bank.sv
module pwm_channel_bank
  import pwm_phase_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int CNT_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  pwm_strobe_t             strobe,
  input  logic [CNT_W-1:0]        cntVal,
  input  logic                    invert,
  input  logic [NUM_CH*CNT_W-1:0] riseCount,
  input  logic [NUM_CH*CNT_W-1:0] fallCount,
  input  logic [NUM_CH-1:0]       forceOn,
  input  logic [NUM_CH-1:0]       forceOff,
  output logic [NUM_CH-1:0]       pwmOut
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [CNT_W-1:0] shRise, shFall;
    logic [CNT_W-1:0] span, pos;
    logic             inWin, level, outBit;

    // Window test on the modular distance from the rise point.
    // Equal counts give an empty window.
    always_comb begin
      span  = shFall - shRise;
      pos   = cntVal - shRise;
      inWin = pos < span;
      if (forceOff[g])     level = 1'b0;
      else if (forceOn[g]) level = 1'b1;
      else                 level = inWin;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shRise <= '0;
        shFall <= '0;
        outBit <= 1'b0;
      end else begin
        if (strobe.load) begin
          shRise <= riseCount[g*CNT_W +: CNT_W];
          shFall <= fallCount[g*CNT_W +: CNT_W];
        end
        outBit <= strobe.hold ? invert : (level ^ invert);
      end
    end

    assign pwmOut[g] = outBit;
  end
endmodule

// File: rtl/pwm_phase_engine.sv
module pwm_phase_engine
  import pwm_phase_pkg::*;
#(
  parameter int NUM_CH  = 16,
  parameter int CNT_W   = 12,
  parameter int PRE_W   = 8,
  parameter int PRE_MIN = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PRE_W-1:0]        prescale,
  input  logic                    sleep,
  input  logic                    invert,
  input  logic [NUM_CH*CNT_W-1:0] riseCount,
  input  logic [NUM_CH*CNT_W-1:0] fallCount,
  input  logic [NUM_CH-1:0]       forceOn,
  input  logic [NUM_CH-1:0]       forceOff,
  output logic [NUM_CH-1:0]       pwmOut
);
  logic [CNT_W-1:0] cntVal;
  pwm_strobe_t      strobe;

  pwm_timebase #(.CNT_W(CNT_W), .PRE_W(PRE_W), .PRE_MIN(PRE_MIN)) u_timebase (
    .clk(clk), .rst_n(rst_n), .prescale(prescale), .sleep(sleep),
    .cntVal(cntVal), .strobe(strobe)
  );

  pwm_channel_bank #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .cntVal(cntVal),
    .invert(invert), .riseCount(riseCount), .fallCount(fallCount),
    .forceOn(forceOn), .forceOff(forceOff), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/pwm_phase_checker.sv
module pwm_phase_checker
  import pwm_phase_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int CNT_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep,
  input logic              invert,
  input logic [NUM_CH-1:0] forceOn,
  input logic [NUM_CH-1:0] forceOff,
  input logic [NUM_CH-1:0] pwmOut,
  input logic [CNT_W-1:0]  cntVal,
  input pwm_strobe_t       strobe
);
  p_sleep_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> $stable(cntVal));

  p_sleep_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (pwmOut == {NUM_CH{$past(invert)}}));

  p_force_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep |=> (((pwmOut ^ {NUM_CH{$past(invert)}}) & $past(forceOff)) == '0));

  p_force_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep |=> (((~(pwmOut ^ {NUM_CH{$past(invert)}})) & $past(forceOn & ~forceOff)) == '0));

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.tick |=> (cntVal == $past(cntVal) + CNT_W'(1)));

  p_count_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.tick |=> $stable(cntVal));

  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.tick |=> !strobe.tick);
endmodule

bind pwm_phase_engine pwm_phase_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep(sleep), .invert(invert),
  .forceOn(forceOn), .forceOff(forceOff), .pwmOut(pwmOut),
  .cntVal(cntVal), .strobe(strobe)
);

// File: tb/pwm_phase_engine_bench.sv
module pwm_phase_engine_bench;
  localparam int NCH = 16;
  localparam int CW  = 12;
  localparam int PW  = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic               rst_n;
  logic [PW-1:0]      prescale;
  logic               sleep, invert;
  logic [CW-1:0]      bRise[NCH];
  logic [CW-1:0]      bFall[NCH];
  logic [NCH-1:0]     forceOn, forceOff;
  logic [NCH*CW-1:0]  riseBus, fallBus;
  logic [NCH-1:0]     pwmOut;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      riseBus[c*CW +: CW] = bRise[c];
      fallBus[c*CW +: CW] = bFall[c];
    end
  end

  pwm_phase_engine u_pwm_phase_engine (
    .clk(clk), .rst_n(rst_n), .prescale(prescale), .sleep(sleep),
    .invert(invert), .riseCount(riseBus), .fallCount(fallBus),
    .forceOn(forceOn), .forceOff(forceOff), .pwmOut(pwmOut)
  );

  // Reference model state
  int mCnt, mPre;
  int mRise[NCH];
  int mFall[NCH];
  logic [NCH-1:0] expOut;
  string expTag[NCH];
  int total, bad;
  bit done, rndOn;

  function automatic int effPre(int p);
    return (p < 3) ? 3 : p;
  endfunction

  // Expected output after the coming edge, then advance the model over that edge.
  task automatic predict();
    logic lvl;
    for (int c = 0; c < NCH; c++) begin
      if (sleep) begin
        expOut[c] = invert;
        expTag[c] = "R8";
      end else begin
        if (forceOff[c]) begin
          lvl = 1'b0; expTag[c] = "R5";
        end else if (forceOn[c]) begin
          lvl = 1'b1; expTag[c] = "R6";
        end else if (mRise[c] == mFall[c]) begin
          lvl = 1'b0; expTag[c] = "R4";
        end else begin
          lvl = (((mCnt - mRise[c]) & 4095) < ((mFall[c] - mRise[c]) & 4095));
          expTag[c] = "R3/R2/R9";
        end
        if (invert) expTag[c] = {expTag[c], "/R7"};
        expOut[c] = lvl ^ invert;
      end
    end
    if (sleep) begin
      for (int c = 0; c < NCH; c++) begin
        mRise[c] = int'(bRise[c]); mFall[c] = int'(bFall[c]);
      end
    end else if (mPre >= effPre(int'(prescale))) begin
      mPre = 0;
      if (mCnt == 4095) begin
        for (int c = 0; c < NCH; c++) begin
          mRise[c] = int'(bRise[c]); mFall[c] = int'(bFall[c]);
        end
      end
      mCnt = (mCnt + 1) % 4096;
    end else begin
      mPre = mPre + 1;
    end
  endtask

  task automatic checkAll();
    for (int c = 0; c < NCH; c++) begin
      total++;
      if (pwmOut[c] !== expOut[c]) begin
        bad++;
        $display("FAIL %s ch%0d at %0t: got %b expected %b", expTag[c], c, $time, pwmOut[c], expOut[c]);
      end
    end
  endtask

  task automatic mutate();
    int r, ch;
    if (!rndOn) return;
    r  = int'($urandom % 4096);
    ch = int'($urandom % NCH);
    if (r < 8) begin
      forceOn[ch]  = (($urandom % 4) == 0);
      forceOff[ch] = (($urandom % 6) == 0);
    end else if (r < 24) begin
      bRise[ch] = CW'($urandom % 4096);
      bFall[ch] = CW'($urandom % 4096);
    end else if (r == 24) begin
      invert = ~invert;
    end
    if (sleep) begin
      if (($urandom % 16) == 0) sleep = 1'b0;
    end else if (($urandom % 6000) == 0) begin
      sleep = 1'b1;
    end
    if (($urandom % 20000) == 0) prescale = PW'($urandom % 8);
  endtask

  task automatic run(int n);
    repeat (n) begin
      predict();
      @(negedge clk);
      checkAll();
      mutate();
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    total = 0; bad = 0; done = 0; rndOn = 0;
    rst_n = 1'b0; prescale = 8'd3; sleep = 1'b0; invert = 1'b0;
    forceOn = '0; forceOff = '0;
    for (int c = 0; c < NCH; c++) begin bRise[c] = '0; bFall[c] = '0; end
    mCnt = 0; mPre = 0;
    for (int c = 0; c < NCH; c++) begin mRise[c] = 0; mFall[c] = 0; end

    // R1: outputs low throughout reset
    repeat (4) begin
      @(negedge clk);
      total++;
      if (pwmOut !== '0) begin
        bad++;
        $display("FAIL R1 reset: got %h expected 0", pwmOut);
      end
    end
    invert = 1'b1;  // R1: reset must also hold outputs low with invert set
    @(negedge clk);
    total++;
    if (pwmOut !== '0) begin
      bad++;
      $display("FAIL R1 reset with invert: got %h expected 0", pwmOut);
    end
    invert = 1'b0;
    rst_n = 1'b1;

    // Directed corner cases, loaded through sleep (R9: buffered counts follow inputs while asleep)
    sleep = 1'b1;
    for (int c = 0; c < NCH; c++) begin
      bRise[c] = CW'($urandom % 4096); bFall[c] = CW'($urandom % 4096);
    end
    bRise[0] = 12'd0;    bFall[0] = 12'd2048;  // R3 plain half duty
    bRise[1] = 12'd4000; bFall[1] = 12'd100;   // R3 window across rollover
    bRise[2] = 12'd500;  bFall[2] = 12'd500;   // R4 equal counts
    forceOn[3] = 1'b1;                          // R6 force high
    forceOn[4] = 1'b1; forceOff[4] = 1'b1;      // R5 force low wins
    bRise[4] = 12'd10;   bFall[4] = 12'd20;
    bRise[5] = 12'd256;  bFall[5] = 12'd1280;  // R3 phase offset
    bRise[6] = 12'd0;    bFall[6] = 12'd4095;  // longest window
    bRise[7] = 12'd4095; bFall[7] = 12'd0;     // one-count window at the last count
    run(3);
    sleep = 1'b0;
    run(17000);

    // R9: change compares mid-period; old window holds until the wrap
    bRise[0] = 12'd1000; bFall[0] = 12'd3000;
    bRise[2] = 12'd3500; bFall[2] = 12'd200;
    forceOn[3] = 1'b0;                          // flags act at once
    run(20000);

    // R2 clamp: prescale below floor, R7 invert, random traffic
    invert = 1'b1;
    prescale = 8'd0;
    rndOn = 1;
    run(40000);

    // Slower divider with random sleep pulses (R8) and further random traffic
    prescale = 8'd6;
    run(60000);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired: got running expected finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule